// File: doc/BRIEF.md
# Root secret register unit

This unit keeps the two on-chip root secrets of a security-extended processor: a 128-bit device key and a 256-bit storage root hash. A one-bit lock flag also lives here. Every access goes through an instruction-style request port. Each request carries an operation code and the execution mode of the issuing code, either normal or trusted concealed. A boot-phase input tells the unit when secure firmware is running. The key and hash registers have no ordinary reset, so they model non-volatile storage. The lock flag is cleared only by a dedicated provisioning reset.

The key can never be read back. Its only use is as the key of an external keyed-MAC engine. A derive request formats a message from fixed purpose constants and nonces. It hands the message and the key to the MAC engine over a valid/ready handshake, then returns the 128-bit result with a one-cycle done pulse.

The MAC port follows these back-pressure rules. Once `mac_valid` rises, it stays high, and `mac_msg`, `mac_len` and `mac_key` stay unchanged, until a cycle in which `mac_ready` is high; the transfer happens in that cycle. The MAC engine answers later with a single-cycle `mac_res_valid`. Only one derivation may be outstanding. Outside an offered request, `mac_key` is driven to zero.

Top module: `rootsec_unit`

## Requirements
- R1: A key write (op 1) is accepted only while `boot_fw` is 1 and the lock is clear. An accepted key is the one presented on `mac_key` by later derivations. A key write with `boot_fw` 0 raises `fault`.
- R2: A lock request (op 2) while `boot_fw` is 1 sets the lock. After that, every key write raises `fault` and leaves the key unchanged. Ordinary reset (`rst_n` low) does not clear the lock.
- R3: Holding `prov_rst` high for a clock edge clears the lock, so that a new key may be written in a provisioning boot.
- R4: A hash write (op 3) or hash read (op 4) is performed only when `req_mode` is 1 (concealed). A permitted read gives `rd_valid` 1 with `rd_data` equal to the stored hash on the cycle after the request.
- R5: Any refused request leaves the key, hash and lock unchanged and raises `fault` for exactly the following cycle. A refused hash read still gives `rd_valid` 1, with `rd_data` all zeros.
- R6: Storage purposes build 3-word messages. Word 0 is placed in bits [511:384], the next word below it, and so on.
  - Purpose 0 (encryption) builds [C_STORAGE=1, C_ENC=3, nonce_a].
  - Purpose 1 (MAC) builds [C_STORAGE=1, C_MAC=4, nonce_a].
  - For both, `mac_len` is 3 and word 3 is zero.
- R7: Session purposes build 4-word messages, with the two nonces in opposite orders.
  - Purpose 2 (authority to device) builds [C_COMM=2, C_A=5, nonce_a, nonce_b].
  - Purpose 3 (device to authority) builds [C_COMM=2, C_D=6, nonce_b, nonce_a].
  - For both, `mac_len` is 4.
- R8: An accepted derive (op 5) raises `mac_valid` on the next cycle and holds it, with the message unchanged, until a cycle with `mac_ready` high. A derive issued while one is outstanding raises `fault`.
- R9: The cycle after `mac_res_valid`, `der_done` pulses for one cycle, with `der_key` equal to `mac_res`.
- R10: A derive issued in normal mode raises `fault` and does not raise `mac_valid`. While `mac_valid` is low, `mac_key` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Ordinary active-low reset; does not touch key, hash or lock |
| prov_rst | input | 1 | Provisioning reset, clears the lock |
| boot_fw | input | 1 | High while secure firmware runs |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 3 | 0 none, 1 key write, 2 lock, 3 hash write, 4 hash read, 5 derive |
| req_mode | input | 1 | 1 concealed trusted mode, 0 normal |
| req_purpose | input | 2 | Derive purpose 0..3 |
| req_data | input | 256 | Write data (key uses bits [127:0]) |
| req_nonce_a | input | 128 | First nonce (node or authority nonce) |
| req_nonce_b | input | 128 | Second nonce (device nonce) |
| fault | output | 1 | One-cycle refusal strobe |
| rd_valid | output | 1 | Hash read response strobe |
| rd_data | output | 256 | Hash read data, zero when refused |
| mac_valid | output | 1 | MAC request offered |
| mac_ready | input | 1 | MAC engine accepts request |
| mac_key | output | 128 | Key for MAC engine, zero when not offered |
| mac_msg | output | 512 | Formatted message, word 0 at the top |
| mac_len | output | 3 | Number of message words used |
| mac_res_valid | input | 1 | MAC result strobe |
| mac_res | input | 128 | MAC result |
| der_done | output | 1 | Derived key ready pulse |
| der_key | output | 128 | Derived key |

## Verification
`fault`, `rd_valid` and `rd_data` are each due one clock edge after the request edge. `mac_valid` with its message is due one edge after an accepted derive. It falls on the edge where `mac_ready` is seen high. `der_done` follows one edge after `mac_res_valid`. The bench changes inputs on the falling edge and samples the outputs on the next falling edge, so every check lands in the single cycle its result is due. During back-pressure it checks the held message on every stalled cycle. Key effects are observed through `mac_key` on later derivations, since the key has no read path.

// File: rtl/rootsec_pkg.sv
package rootsec_pkg;
  localparam int KEY_W     = 128;
  localparam int HASH_W    = 256;
  localparam int MSG_WORDS = 4;
  localparam int MSG_W     = KEY_W * MSG_WORDS;
  localparam int LEN_W     = $clog2(MSG_WORDS + 1);

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_KEY_WR  = 3'd1,
    OP_LOCK    = 3'd2,
    OP_HASH_WR = 3'd3,
    OP_HASH_RD = 3'd4,
    OP_DERIVE  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    PUR_ST_ENC = 2'd0,
    PUR_ST_MAC = 2'd1,
    PUR_A2D    = 2'd2,
    PUR_D2A    = 2'd3
  } purpose_e;

  localparam logic [KEY_W-1:0] C_STORAGE = KEY_W'(1);
  localparam logic [KEY_W-1:0] C_COMM    = KEY_W'(2);
  localparam logic [KEY_W-1:0] C_ENC     = KEY_W'(3);
  localparam logic [KEY_W-1:0] C_MAC     = KEY_W'(4);
  localparam logic [KEY_W-1:0] C_A       = KEY_W'(5);
  localparam logic [KEY_W-1:0] C_D       = KEY_W'(6);
endpackage

// File: rtl/rootsec_key_lock.sv
module rootsec_key_lock
  import rootsec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prov_rst,
  input  logic             wr_en,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             set_lock,
  output logic [KEY_W-1:0] key_q,
  output logic             locked
);
  logic [KEY_W-1:0] key_r;
  logic             lock_r;

  // non-volatile: no ordinary reset
  always_ff @(posedge clk) begin
    if (wr_en && !lock_r)
      key_r <= wr_key;
  end

  always_ff @(posedge clk) begin
    if (prov_rst)
      lock_r <= 1'b0;
    else if (set_lock)
      lock_r <= 1'b1;
  end

  assign key_q  = key_r;
  assign locked = lock_r;

  assert_key_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_r && !prov_rst) |=> $stable(key_r));

  assert_lock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_r && !prov_rst) |=> lock_r);
endmodule

// File: rtl/rootsec_hash_reg.sv
module rootsec_hash_reg
  import rootsec_pkg::*;
(
  input  logic              clk,
  input  logic              wr_en,
  input  logic [HASH_W-1:0] wr_data,
  output logic [HASH_W-1:0] hash_q
);
  logic [HASH_W-1:0] hash_r;

  always_ff @(posedge clk) begin
    if (wr_en)
      hash_r <= wr_data;
  end

  assign hash_q = hash_r;
endmodule

// File: rtl/rootsec_derive.sv
module rootsec_derive
  import rootsec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       purpose,
  input  logic [KEY_W-1:0] nonce_a,
  input  logic [KEY_W-1:0] nonce_b,
  input  logic [KEY_W-1:0] key,
  output logic             idle,
  output logic             mac_valid,
  input  logic             mac_ready,
  output logic [KEY_W-1:0] mac_key,
  output logic [MSG_W-1:0] mac_msg,
  output logic [LEN_W-1:0] mac_len,
  input  logic             mac_res_valid,
  input  logic [KEY_W-1:0] mac_res,
  output logic             der_done,
  output logic [KEY_W-1:0] der_key
);
  typedef enum logic [1:0] {D_IDLE, D_REQ, D_WAIT} dstate_e;
  dstate_e state;

  logic [KEY_W-1:0] words_d [MSG_WORDS];
  logic [KEY_W-1:0] words_q [MSG_WORDS];
  logic [LEN_W-1:0] len_d, len_q;

  always_comb begin
    for (int i = 0; i < MSG_WORDS; i++) words_d[i] = '0;
    len_d = LEN_W'(3);
    case (purpose_e'(purpose))
      PUR_ST_ENC: begin
        words_d[0] = C_STORAGE; words_d[1] = C_ENC; words_d[2] = nonce_a;
      end
      PUR_ST_MAC: begin
        words_d[0] = C_STORAGE; words_d[1] = C_MAC; words_d[2] = nonce_a;
      end
      PUR_A2D: begin
        words_d[0] = C_COMM; words_d[1] = C_A;
        words_d[2] = nonce_a; words_d[3] = nonce_b;
        len_d = LEN_W'(4);
      end
      default: begin
        words_d[0] = C_COMM; words_d[1] = C_D;
        words_d[2] = nonce_b; words_d[3] = nonce_a;
        len_d = LEN_W'(4);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= D_IDLE;
      der_done <= 1'b0;
      der_key  <= '0;
    end else begin
      der_done <= 1'b0;
      case (state)
        D_IDLE: if (start) state <= D_REQ;
        D_REQ:  if (mac_ready) state <= D_WAIT;
        D_WAIT: if (mac_res_valid) begin
          der_done <= 1'b1;
          der_key  <= mac_res;
          state    <= D_IDLE;
        end
        default: state <= D_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == D_IDLE && start) begin
      for (int i = 0; i < MSG_WORDS; i++) words_q[i] <= words_d[i];
      len_q <= len_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < MSG_WORDS; g++) begin : g_flat
      assign mac_msg[MSG_W-1-g*KEY_W -: KEY_W] = words_q[g];
    end
  endgenerate

  assign idle      = (state == D_IDLE);
  assign mac_valid = (state == D_REQ);
  assign mac_len   = len_q;
  assign mac_key   = (state == D_REQ) ? key : '0;

  assert_mac_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_valid && !mac_ready) |=> (mac_valid && $stable(mac_msg) && $stable(mac_len)));

  assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == D_WAIT && mac_res_valid) |=> (der_done && der_key == $past(mac_res)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    der_done |=> !der_done);
endmodule

// File: rtl/rootsec_unit.sv
module rootsec_unit
  import rootsec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prov_rst,
  input  logic              boot_fw,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic              req_mode,
  input  logic [1:0]        req_purpose,
  input  logic [HASH_W-1:0] req_data,
  input  logic [KEY_W-1:0]  req_nonce_a,
  input  logic [KEY_W-1:0]  req_nonce_b,
  output logic              fault,
  output logic              rd_valid,
  output logic [HASH_W-1:0] rd_data,
  output logic              mac_valid,
  input  logic              mac_ready,
  output logic [KEY_W-1:0]  mac_key,
  output logic [MSG_W-1:0]  mac_msg,
  output logic [LEN_W-1:0]  mac_len,
  input  logic              mac_res_valid,
  input  logic [KEY_W-1:0]  mac_res,
  output logic              der_done,
  output logic [KEY_W-1:0]  der_key
);
  op_e               op;
  logic              locked, der_idle;
  logic [KEY_W-1:0]  key_q;
  logic [HASH_W-1:0] hash_q;
  logic              key_we, lock_set, hash_we, hash_re, der_go, deny;

  always_comb begin
    op       = op_e'(req_op);
    key_we   = 1'b0;
    lock_set = 1'b0;
    hash_we  = 1'b0;
    hash_re  = 1'b0;
    der_go   = 1'b0;
    deny     = 1'b0;
    if (req_valid) begin
      case (op)
        OP_NONE:    ;
        OP_KEY_WR:  if (boot_fw && !locked) key_we = 1'b1; else deny = 1'b1;
        OP_LOCK:    if (boot_fw) lock_set = 1'b1; else deny = 1'b1;
        OP_HASH_WR: if (req_mode) hash_we = 1'b1; else deny = 1'b1;
        OP_HASH_RD: if (req_mode) hash_re = 1'b1; else deny = 1'b1;
        OP_DERIVE:  if (req_mode && der_idle) der_go = 1'b1; else deny = 1'b1;
        default:    deny = 1'b1;
      endcase
    end
  end

  rootsec_key_lock u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .prov_rst (prov_rst),
    .wr_en    (key_we),
    .wr_key   (req_data[KEY_W-1:0]),
    .set_lock (lock_set),
    .key_q    (key_q),
    .locked   (locked)
  );

  rootsec_hash_reg u_hash (
    .clk     (clk),
    .wr_en   (hash_we),
    .wr_data (req_data),
    .hash_q  (hash_q)
  );

  rootsec_derive u_der (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (der_go),
    .purpose       (req_purpose),
    .nonce_a       (req_nonce_a),
    .nonce_b       (req_nonce_b),
    .key           (key_q),
    .idle          (der_idle),
    .mac_valid     (mac_valid),
    .mac_ready     (mac_ready),
    .mac_key       (mac_key),
    .mac_msg       (mac_msg),
    .mac_len       (mac_len),
    .mac_res_valid (mac_res_valid),
    .mac_res       (mac_res),
    .der_done      (der_done),
    .der_key       (der_key)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      fault    <= deny;
      rd_valid <= req_valid && (op == OP_HASH_RD);
      rd_data  <= hash_re ? hash_q : '0;
    end
  end

  assert_hash_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd3 && !req_mode) |=> ($stable(hash_q) && fault));

  assert_rd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && fault) |-> (rd_data == '0));

  assert_busy_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd5 && mac_valid) |=> fault);

  assert_key_hidden_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mac_valid |-> (mac_key == '0));
endmodule

// File: tb/rootsec_unit_test.sv
module rootsec_unit_test;
  localparam int KW = 128;
  localparam int HW = 256;
  localparam int MW = 512;

  logic clk = 0;
  logic rst_n = 0, prov_rst = 0, boot_fw = 0;
  logic req_valid = 0, req_mode = 0;
  logic [2:0] req_op = 0;
  logic [1:0] req_purpose = 0;
  logic [HW-1:0] req_data = 0;
  logic [KW-1:0] req_nonce_a = 0, req_nonce_b = 0;
  logic fault, rd_valid, mac_valid, der_done;
  logic [HW-1:0] rd_data;
  logic mac_ready = 0, mac_res_valid = 0;
  logic [KW-1:0] mac_key, mac_res = 0, der_key;
  logic [MW-1:0] mac_msg;
  logic [2:0] mac_len;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rootsec_unit uut (.*);

  localparam logic [KW-1:0] K1 = {4{32'hA5C3_1E77}};
  localparam logic [KW-1:0] K2 = {4{32'h0BAD_F00D}};
  localparam logic [KW-1:0] K3 = {4{32'h1357_9BDF}};
  localparam logic [HW-1:0] H1 = {8{32'hCAFE_0001}};
  localparam logic [HW-1:0] H2 = {8{32'hDEAD_0002}};

  task automatic chk(input bit ok, input string tag, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic do_req(input logic [2:0] op, input logic mode, input logic [HW-1:0] d,
                        input logic [1:0] pur, input logic [KW-1:0] na, input logic [KW-1:0] nb);
    @(negedge clk);
    req_valid = 1; req_op = op; req_mode = mode; req_data = d;
    req_purpose = pur; req_nonce_a = na; req_nonce_b = nb;
    @(negedge clk);
    req_valid = 0; req_op = 0;
  endtask

  function automatic logic [MW-1:0] msg_of(input logic [KW-1:0] w0, w1, w2, w3);
    return {w0, w1, w2, w3};
  endfunction

  // runs one derivation with stall cycles, checking message, key and result
  task automatic derive_run(input string tag, input logic [1:0] pur, input logic [KW-1:0] na,
                            input logic [KW-1:0] nb, input int stall, input logic [MW-1:0] exp_msg,
                            input logic [2:0] exp_len, input logic [KW-1:0] exp_key);
    logic [KW-1:0] res;
    do_req(3'd5, 1'b1, '0, pur, na, nb);
    chk1({tag, " R8 mac_valid"}, MW'(mac_valid), MW'(1));
    chk1({tag, " msg"}, mac_msg, exp_msg);
    chk1({tag, " len"}, MW'(mac_len), MW'(exp_len));
    chk1({tag, " R1 key"}, MW'(mac_key), MW'(exp_key));
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk1({tag, " R8 held valid"}, MW'(mac_valid), MW'(1));
      chk1({tag, " R8 held msg"}, mac_msg, exp_msg);
    end
    mac_ready = 1;
    @(negedge clk);
    mac_ready = 0;
    chk1({tag, " R8 valid drop"}, MW'(mac_valid), MW'(0));
    chk1({tag, " R10 key zero"}, MW'(mac_key), MW'(0));
    res = exp_key ^ {KW{1'b1}} ^ KW'(pur);
    mac_res_valid = 1; mac_res = res;
    @(negedge clk);
    mac_res_valid = 0; mac_res = 0;
    chk1({tag, " R9 done"}, MW'(der_done), MW'(1));
    chk1({tag, " R9 result"}, MW'(der_key), MW'(res));
    @(negedge clk);
    chk1({tag, " R9 done pulse"}, MW'(der_done), MW'(0));
  endtask

  task automatic t_reset;
    chk1("R5 reset fault", MW'(fault), MW'(0));
    chk1("R4 reset rd_valid", MW'(rd_valid), MW'(0));
    chk1("R8 reset mac_valid", MW'(mac_valid), MW'(0));
    chk1("R9 reset der_done", MW'(der_done), MW'(0));
  endtask

  task automatic t_provision;
    @(negedge clk); prov_rst = 1; @(negedge clk); prov_rst = 0;
    do_req(3'd1, 1'b0, HW'(K2), 0, 0, 0);
    chk1("R1 key write outside firmware", MW'(fault), MW'(1));
    boot_fw = 1;
    do_req(3'd1, 1'b0, HW'(K1), 0, 0, 0);
    chk1("R1 key write accepted", MW'(fault), MW'(0));
    do_req(3'd2, 1'b0, '0, 0, 0, 0);
    chk1("R2 lock accepted", MW'(fault), MW'(0));
    do_req(3'd1, 1'b0, HW'(K2), 0, 0, 0);
    chk1("R2 key write after lock", MW'(fault), MW'(1));
    @(negedge clk);
    chk1("R5 fault one cycle", MW'(fault), MW'(0));
    rst_n = 0; @(negedge clk); rst_n = 1;
    do_req(3'd1, 1'b0, HW'(K2), 0, 0, 0);
    chk1("R2 lock survives reset", MW'(fault), MW'(1));
    boot_fw = 0;
  endtask

  task automatic t_hash;
    do_req(3'd3, 1'b1, H1, 0, 0, 0);
    chk1("R4 hash write concealed", MW'(fault), MW'(0));
    do_req(3'd4, 1'b1, '0, 0, 0, 0);
    chk1("R4 hash read valid", MW'(rd_valid), MW'(1));
    chk1("R4 hash read data", MW'(rd_data), MW'(H1));
    do_req(3'd3, 1'b0, H2, 0, 0, 0);
    chk1("R5 hash write normal fault", MW'(fault), MW'(1));
    do_req(3'd4, 1'b0, '0, 0, 0, 0);
    chk1("R5 hash read normal fault", MW'(fault), MW'(1));
    chk1("R5 hash read normal valid", MW'(rd_valid), MW'(1));
    chk1("R5 hash read normal zeros", MW'(rd_data), MW'(0));
    do_req(3'd4, 1'b1, '0, 0, 0, 0);
    chk1("R5 hash unchanged", MW'(rd_data), MW'(H1));
  endtask

  task automatic t_derive;
    logic [KW-1:0] na, nb;
    na = {4{32'h1111_2222}}; nb = {4{32'h3333_4444}};
    chk1("R10 idle key zero", MW'(mac_key), MW'(0));
    derive_run("R6 enc", 2'd0, na, nb, 0, msg_of(KW'(1), KW'(3), na, KW'(0)), 3'd3, K1);
    derive_run("R6 mac", 2'd1, nb, na, 2, msg_of(KW'(1), KW'(4), nb, KW'(0)), 3'd3, K1);
    derive_run("R7 a2d", 2'd2, na, nb, 1, msg_of(KW'(2), KW'(5), na, nb), 3'd4, K1);
    derive_run("R7 d2a", 2'd3, na, nb, 3, msg_of(KW'(2), KW'(6), nb, na), 3'd4, K1);
    do_req(3'd5, 1'b0, '0, 2'd0, na, nb);
    chk1("R10 derive normal fault", MW'(fault), MW'(1));
    chk1("R10 derive normal no valid", MW'(mac_valid), MW'(0));
  endtask

  task automatic t_busy;
    logic [KW-1:0] na;
    na = {4{32'h5555_6666}};
    do_req(3'd5, 1'b1, '0, 2'd0, na, '0);
    chk1("R8 busy first valid", MW'(mac_valid), MW'(1));
    do_req(3'd5, 1'b1, '0, 2'd2, '0, '0);
    chk1("R8 busy second fault", MW'(fault), MW'(1));
    chk1("R8 busy msg kept", mac_msg, msg_of(KW'(1), KW'(3), na, KW'(0)));
    mac_ready = 1; @(negedge clk); mac_ready = 0;
    mac_res_valid = 1; mac_res = K3; @(negedge clk); mac_res_valid = 0;
    chk1("R9 busy result", MW'(der_key), MW'(K3));
  endtask

  task automatic t_reprovision;
    boot_fw = 1;
    @(negedge clk); prov_rst = 1; @(negedge clk); prov_rst = 0;
    do_req(3'd1, 1'b0, HW'(K3), 0, 0, 0);
    chk1("R3 key write after prov reset", MW'(fault), MW'(0));
    do_req(3'd2, 1'b0, '0, 0, 0, 0);
    boot_fw = 0;
    derive_run("R3 new key", 2'd2, KW'(7), KW'(9), 0, msg_of(KW'(2), KW'(5), KW'(7), KW'(9)), 3'd4, K3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_provision;
    t_hash;
    t_derive;
    t_busy;
    t_reprovision;
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule